// File: doc/BRIEF.md
# Masked Indirect Memory Access Unit

This unit runs single-cycle access instructions against a small store of 64-bit words. Each word carries a validity flag. Every instruction moves one 32-bit half of a word across a 32-bit data path, and a half-select input chooses which half. The word is named in one of two ways. The first is an internal address pointer, which moves one place up or down after each access. The second is a match index supplied from outside, together with a match-found flag. Both come from comparison logic that sits outside this block.

A write can be limited bit by bit using one of seven 64-bit mask registers, which are loaded through a separate port. A mask bit of 1 protects the stored bit. A write also sets the word's validity flag from an active-low valid input. A read returns the selected half and the word's flag on registered outputs, one cycle after the instruction. An output-enable drives the external tri-state buffer, and this block's data and flag outputs are valid only while it is high.

Top module: `maiu_top`

## Requirements
- R1: After reset `rdOe` is 0, `vbOut` is 1, `dqOut` is 0, the address pointer is 0, every word is 0 and empty, and every mask register is 0.
- R2: Operation code `instr[5:0]` = 6'b100110 accesses the word at the address pointer and then adds one to the pointer, wrapping from 15 to 0.
- R3: Operation code 6'b100111 accesses the word at the address pointer and then subtracts one from the pointer, wrapping from 0 to 15.
- R4: `halfSel` = 0 accesses bits 31:0 of the word and `halfSel` = 1 accesses bits 63:32. A write leaves the other half unchanged.
- R5: A write stores validity = NOT `vbIn`, so 0 means valid and 1 means empty. A read returns `vbOut` = 0 for a valid word and 1 for an empty one. `vbOut` is 1 whenever `rdOe` is 0.
- R6: Mask select `instr[8:6]` = 0 makes the write unmasked. A value k from 1 to 7 applies the matching half of mask register k: bits whose mask bit is 1 keep their old value. Mask register k is loaded from `maskData` when `maskWe` is high and `maskAddr` = k. `maskAddr` = 0 is ignored.
- R7: Operation code 6'b000010 with `matchFound` = 1 accesses the word at `matchIdx` and leaves the address pointer unchanged.
- R8: Operation code 6'b000010 with `matchFound` = 0 changes no state. A read of this kind leaves `rdOe` at 0, so the bus stays in high impedance.
- R9: `wrN` = 1 selects a read and `wrN` = 0 selects a write. Read results appear on `dqOut` and `vbOut` with `rdOe` = 1 in the cycle after the instruction is sampled. `rdOe` is 0 after any cycle without a read, and `dqOut` holds its value then.
- R10: An unrecognised operation code, or `exec` = 0, changes no state. Bits `instr[11:9]` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| exec | input | 1 | Instruction is sampled when high |
| instr | input | 12 | Instruction: [8:6] mask select, [5:0] operation |
| wrN | input | 1 | 0 = write, 1 = read |
| halfSel | input | 1 | 0 = bits 31:0, 1 = bits 63:32 |
| dqIn | input | 32 | Write data |
| vbIn | input | 1 | Validity to store, 0 = valid |
| matchIdx | input | 4 | Highest-priority match index |
| matchFound | input | 1 | Last comparison found a match |
| maskWe | input | 1 | Mask register load strobe |
| maskAddr | input | 3 | Mask register to load (1..7) |
| maskData | input | 64 | Mask load value |
| dqOut | output | 32 | Registered read data |
| vbOut | output | 1 | Registered validity of the word read, 0 = valid |
| rdOe | output | 1 | Output enable for the data and validity drivers |

## Verification
A wrong address pointer shows up as data from the wrong word on the next read. Because the pointer wraps through 16 words, long runs of indirect reads and writes reveal a missing or doubled step within a few accesses. A wrong stored mask or validity flag shows up only when the affected word is read again, so the random mix reads words back soon after they are written and loads masks while traffic continues. Output-enable and read-data errors show up in the very next cycle.

// File: rtl/maiu_pkg.sv
package maiu_pkg;
  localparam int DATA_W   = 32;
  localparam int WORD_W   = 2 * DATA_W;
  localparam int DEPTH    = 16;
  localparam int ADDR_W   = $clog2(DEPTH);
  localparam int MASK_CNT = 7;
  localparam int MSEL_W   = $clog2(MASK_CNT + 1);
  localparam int INSTR_W  = 12;
  localparam int OP_W     = 6;

  localparam logic [OP_W-1:0] OP_STEP_UP = 6'b100110;
  localparam logic [OP_W-1:0] OP_STEP_DN = 6'b100111;
  localparam logic [OP_W-1:0] OP_HPM     = 6'b000010;

  typedef struct packed {
    logic              wrEn;
    logic              rdEn;
    logic              useHpm;
    logic              stepUp;
    logic              stepDn;
    logic              half;
    logic [MSEL_W-1:0] maskSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/maiu_ctrl.sv
module maiu_ctrl
  import maiu_pkg::*;
(
  input  logic               exec,
  input  logic [INSTR_W-1:0] instr,
  input  logic               wrN,
  input  logic               halfSel,
  input  logic               matchFound,
  output ctrlStrobes_t       strb
);
  logic [OP_W-1:0] opCode;
  logic isUp, isDn, isHpm, doAccess;

  always_comb begin
    opCode   = instr[OP_W-1:0];
    isUp     = (opCode == OP_STEP_UP);
    isDn     = (opCode == OP_STEP_DN);
    isHpm    = (opCode == OP_HPM);
    doAccess = exec && (isUp || isDn || (isHpm && matchFound));

    strb.wrEn    = doAccess && !wrN;
    strb.rdEn    = doAccess && wrN;
    strb.useHpm  = isHpm;
    strb.stepUp  = exec && isUp;
    strb.stepDn  = exec && isDn;
    strb.half    = halfSel;
    strb.maskSel = instr[OP_W+MSEL_W-1:OP_W];
  end
endmodule

// File: rtl/maiu_datapath.sv
module maiu_datapath
  import maiu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [DATA_W-1:0] dqIn,
  input  logic              vbIn,
  input  logic [ADDR_W-1:0] matchIdx,
  input  logic              maskWe,
  input  logic [MSEL_W-1:0] maskAddr,
  input  logic [WORD_W-1:0] maskData,
  output logic [DATA_W-1:0] dqOut,
  output logic              vbOut,
  output logic              rdOe
);
  logic [WORD_W-1:0] memWord  [DEPTH];
  logic              memValid [DEPTH];
  logic [WORD_W-1:0] maskBank [MASK_CNT+1];
  logic [ADDR_W-1:0] addrReg;

  logic [ADDR_W-1:0] tgtIdx;
  logic [WORD_W-1:0] oldWord, selMask, newWord;
  logic [DATA_W-1:0] oldHalf, maskHalf, mergedHalf;

  // Mask bank: entry 0 is the permanent all-zero "no mask" value
  assign maskBank[0] = '0;
  for (genvar k = 1; k <= MASK_CNT; k++) begin : g_mask
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                    maskBank[k] <= '0;
      else if (maskWe && maskAddr == MSEL_W'(k))    maskBank[k] <= maskData;
    end
  end

  always_comb begin
    tgtIdx     = strb.useHpm ? matchIdx : addrReg;
    oldWord    = memWord[tgtIdx];
    selMask    = maskBank[strb.maskSel];
    oldHalf    = strb.half ? oldWord[WORD_W-1:DATA_W] : oldWord[DATA_W-1:0];
    maskHalf   = strb.half ? selMask[WORD_W-1:DATA_W] : selMask[DATA_W-1:0];
    mergedHalf = (oldHalf & maskHalf) | (dqIn & ~maskHalf);
    newWord    = strb.half ? {mergedHalf, oldWord[DATA_W-1:0]}
                           : {oldWord[WORD_W-1:DATA_W], mergedHalf};
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic hit;
    assign hit = strb.wrEn && (tgtIdx == ADDR_W'(e));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        memWord[e]  <= '0;
        memValid[e] <= 1'b0;
      end else if (hit) begin
        memWord[e]  <= newWord;
        memValid[e] <= !vbIn;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            addrReg <= '0;
    else if (strb.stepUp) addrReg <= addrReg + 1'b1;
    else if (strb.stepDn) addrReg <= addrReg - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dqOut <= '0;
      vbOut <= 1'b1;
      rdOe  <= 1'b0;
    end else begin
      rdOe  <= strb.rdEn;
      vbOut <= strb.rdEn ? !memValid[tgtIdx] : 1'b1;
      if (strb.rdEn) dqOut <= oldHalf;
    end
  end
endmodule

// File: rtl/maiu_top.sv
module maiu_top
  import maiu_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               exec,
  input  logic [INSTR_W-1:0] instr,
  input  logic               wrN,
  input  logic               halfSel,
  input  logic [DATA_W-1:0]  dqIn,
  input  logic               vbIn,
  input  logic [ADDR_W-1:0]  matchIdx,
  input  logic               matchFound,
  input  logic               maskWe,
  input  logic [MSEL_W-1:0]  maskAddr,
  input  logic [WORD_W-1:0]  maskData,
  output logic [DATA_W-1:0]  dqOut,
  output logic               vbOut,
  output logic               rdOe
);
  ctrlStrobes_t strb;

  maiu_ctrl u_ctrl (
    .exec(exec), .instr(instr), .wrN(wrN), .halfSel(halfSel),
    .matchFound(matchFound), .strb(strb)
  );

  maiu_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .dqIn(dqIn), .vbIn(vbIn),
    .matchIdx(matchIdx), .maskWe(maskWe), .maskAddr(maskAddr),
    .maskData(maskData), .dqOut(dqOut), .vbOut(vbOut), .rdOe(rdOe)
  );
endmodule

// File: rtl/maiu_checker.sv
module maiu_checker
  import maiu_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               exec,
  input logic [INSTR_W-1:0] instr,
  input logic               wrN,
  input logic               matchFound,
  input logic [DATA_W-1:0]  dqOut,
  input logic               vbOut,
  input logic               rdOe
);
  logic indRead, hpmMissRead;
  assign indRead     = exec && wrN && (instr[OP_W-1:0] == OP_STEP_UP ||
                                       instr[OP_W-1:0] == OP_STEP_DN);
  assign hpmMissRead = exec && wrN && instr[OP_W-1:0] == OP_HPM && !matchFound;

  a_r1_reset_quiet: assert property (@(posedge clk)
    $rose(rstN) |-> (!rdOe && vbOut));

  a_r9_oe_after_read: assert property (@(posedge clk) disable iff (!rstN)
    indRead |=> rdOe);

  a_r8_miss_stays_hiz: assert property (@(posedge clk) disable iff (!rstN)
    hpmMissRead |=> !rdOe);

  a_r9_oe_needs_read: assert property (@(posedge clk) disable iff (!rstN)
    !(exec && wrN) |=> !rdOe);

  a_r9_data_held: assert property (@(posedge clk) disable iff (!rstN)
    !(exec && wrN) |=> $stable(dqOut));

  a_r5_vb_released: assert property (@(posedge clk) disable iff (!rstN)
    !rdOe |-> vbOut);
endmodule

bind maiu_top maiu_checker u_chk (
  .clk(clk), .rstN(rstN), .exec(exec), .instr(instr), .wrN(wrN),
  .matchFound(matchFound), .dqOut(dqOut), .vbOut(vbOut), .rdOe(rdOe)
);

// File: tb/maiu_top_tb.sv
module maiu_top_tb;
  import maiu_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic exec = 1'b0;
  logic [INSTR_W-1:0] instr = '0;
  logic wrN = 1'b1, halfSel = 1'b0, vbIn = 1'b1, matchFound = 1'b0, maskWe = 1'b0;
  logic [DATA_W-1:0] dqIn = '0;
  logic [ADDR_W-1:0] matchIdx = '0;
  logic [MSEL_W-1:0] maskAddr = '0;
  logic [WORD_W-1:0] maskData = '0;
  logic [DATA_W-1:0] dqOut;
  logic vbOut, rdOe;

  always #5ns clk = ~clk;

  maiu_top u_dut (.*);

  logic [WORD_W-1:0] mMem [DEPTH];
  logic              mVal [DEPTH];
  logic [WORD_W-1:0] mMask [MASK_CNT+1];
  int mAddr;
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  function automatic logic [WORD_W-1:0] mergeWord(input logic [WORD_W-1:0] oldW,
      input logic [WORD_W-1:0] m, input logic [DATA_W-1:0] d, input logic h);
    logic [WORD_W-1:0] r;
    r = oldW;
    if (h) r[WORD_W-1:DATA_W] = (oldW[WORD_W-1:DATA_W] & m[WORD_W-1:DATA_W]) | (d & ~m[WORD_W-1:DATA_W]);
    else   r[DATA_W-1:0]      = (oldW[DATA_W-1:0] & m[DATA_W-1:0]) | (d & ~m[DATA_W-1:0]);
    return r;
  endfunction

  task automatic loadMask(input logic [MSEL_W-1:0] k, input logic [WORD_W-1:0] v);
    @(negedge clk);
    maskWe = 1'b1; maskAddr = k; maskData = v;
    if (k != 0) mMask[k] = v;
    @(negedge clk);
    maskWe = 1'b0;
  endtask

  task automatic issue(input string req, input logic [INSTR_W-1:0] ins, input logic w,
      input logic h, input logic [DATA_W-1:0] d, input logic v,
      input logic [ADDR_W-1:0] mi, input logic mf);
    logic [OP_W-1:0] op;
    logic act, hpm;
    int tgt;
    logic [DATA_W-1:0] expD;
    logic expVb, expOe;
    op  = ins[OP_W-1:0];
    hpm = (op == OP_HPM);
    act = (op == OP_STEP_UP) || (op == OP_STEP_DN) || (hpm && mf);
    tgt = hpm ? int'(mi) : mAddr;
    expOe = act && w;
    expD  = h ? mMem[tgt][WORD_W-1:DATA_W] : mMem[tgt][DATA_W-1:0];
    expVb = !mVal[tgt];
    @(negedge clk);
    exec = 1'b1; instr = ins; wrN = w; halfSel = h; dqIn = d; vbIn = v;
    matchIdx = mi; matchFound = mf;
    if (act && !w) begin
      mMem[tgt] = mergeWord(mMem[tgt], mMask[ins[OP_W+MSEL_W-1:OP_W]], d, h);
      mVal[tgt] = !v;
    end
    if (op == OP_STEP_UP) mAddr = (mAddr + 1) % DEPTH;
    if (op == OP_STEP_DN) mAddr = (mAddr + DEPTH - 1) % DEPTH;
    @(negedge clk);
    exec = 1'b0;
    chk({req, " oe"}, WORD_W'(rdOe), WORD_W'(expOe));
    if (expOe) begin
      chk({req, " data"}, WORD_W'(dqOut), WORD_W'(expD));
      chk({req, " vb"}, WORD_W'(vbOut), WORD_W'(expVb));
    end else begin
      chk({req, " vb idle (R5)"}, WORD_W'(vbOut), WORD_W'(1'b1));
    end
  endtask

  function automatic logic [INSTR_W-1:0] mk(input logic [2:0] nnn, input logic [OP_W-1:0] op);
    return {3'($urandom), nnn, op};
  endfunction

  initial begin
    #2ms;
    fails++; checks++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < DEPTH; i++) begin mMem[i] = '0; mVal[i] = 1'b0; end
    for (int i = 0; i <= MASK_CNT; i++) mMask[i] = '0;
    mAddr = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    chk("R1 oe", WORD_W'(rdOe), '0);
    chk("R1 vb", WORD_W'(vbOut), WORD_W'(1'b1));
    chk("R1 dq", WORD_W'(dqOut), '0);
    issue("R1 first read", mk(0, OP_STEP_UP), 1, 0, 0, 1, 0, 0);
    // R2 wrap upward through all entries, writing each
    for (int i = 0; i < DEPTH; i++)
      issue("R2 write", mk(0, OP_STEP_UP), 0, 1'(i), 32'hA000_0000 + i, 1'(i), 0, 0);
    for (int i = 0; i < DEPTH + 1; i++)
      issue("R2 readback", mk(0, OP_STEP_UP), 1, 1'(i), 0, 0, 0, 0);
    // R3 wrap downward below zero
    while (mAddr != 0) issue("R3 walk", mk(0, OP_STEP_DN), 1, 0, 0, 0, 0, 0);
    issue("R3 wrap", mk(0, OP_STEP_DN), 0, 0, 32'h1234_5678, 0, 0, 0);
    issue("R3 at last entry", mk(0, OP_STEP_DN), 1, 0, 0, 0, 0, 0);
    // R4 halves independent
    issue("R4 high write", mk(0, OP_HPM), 0, 1, 32'hDEAD_BEEF, 0, 4'd5, 1);
    issue("R4 low intact", mk(0, OP_HPM), 1, 0, 0, 0, 4'd5, 1);
    issue("R4 high read", mk(0, OP_HPM), 1, 1, 0, 0, 4'd5, 1);
    // R6 masked write and ignored mask address 0
    loadMask(3'd3, 64'hFFFF_0000_0F0F_F0F0);
    loadMask(3'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    issue("R6 masked low", mk(3, OP_HPM), 0, 0, 32'h5555_AAAA, 0, 4'd7, 1);
    issue("R6 masked low read", mk(0, OP_HPM), 1, 0, 0, 0, 4'd7, 1);
    issue("R6 masked high", mk(3, OP_HPM), 0, 1, 32'h1357_9BDF, 0, 4'd7, 1);
    issue("R6 masked high read", mk(0, OP_HPM), 1, 1, 0, 0, 4'd7, 1);
    issue("R6 sel0 unmasked", mk(0, OP_HPM), 0, 0, 32'hCAFE_F00D, 1, 4'd7, 1);
    issue("R6 sel0 read", mk(0, OP_HPM), 1, 0, 0, 0, 4'd7, 1);
    // R7 pointer unchanged by match access
    issue("R7 hpm read", mk(0, OP_HPM), 1, 0, 0, 0, 4'd2, 1);
    issue("R7 pointer kept", mk(0, OP_STEP_UP), 1, 0, 0, 0, 0, 0);
    // R8 no match: no write, no drive
    issue("R8 miss write", mk(0, OP_HPM), 0, 0, 32'hFFFF_FFFF, 0, 4'd9, 0);
    issue("R8 miss read", mk(0, OP_HPM), 1, 0, 0, 0, 4'd9, 0);
    issue("R8 entry intact", mk(0, OP_HPM), 1, 0, 0, 0, 4'd9, 1);
    // R10 unknown op
    issue("R10 bad op write", mk(0, 6'b111111), 0, 0, 32'h0BAD_0BAD, 0, 0, 1);
    issue("R10 bad op read", mk(0, 6'b000000), 1, 0, 0, 0, 0, 1);
    issue("R10 state kept", mk(0, OP_STEP_UP), 1, 0, 0, 0, 0, 0);
    // Random mix (R9 timing on every check)
    for (int n = 0; n < 400; n++) begin
      int pick;
      logic [OP_W-1:0] op;
      string tag;
      pick = int'($urandom % 10);
      if (pick < 3)      begin op = OP_STEP_UP; tag = "R2 rand"; end
      else if (pick < 6) begin op = OP_STEP_DN; tag = "R3 rand"; end
      else if (pick < 9) begin op = OP_HPM;     tag = "R7 rand"; end
      else               begin op = 6'($urandom); tag = "R10 rand"; end
      if ($urandom % 16 == 0) loadMask(3'($urandom), {$urandom, $urandom});
      issue({tag, " R9"}, mk(3'($urandom), op), 1'($urandom), 1'($urandom), $urandom,
            1'($urandom), 4'($urandom), ($urandom % 5) != 0);
    end
    finishRun();
  end
endmodule